// File: doc/BRIEF.md
# Dual Input Capture Timer

This block timestamps transitions on two external signals. A free-running 16-bit down-counter (counter 1) advances on its own clock-enable tick. A qualifying transition on input A latches the counter into the A capture register, and a transition on input B latches it into the B capture register. Each input can be set to react to rising or to falling transitions. Each input can also be set to reload counter 1 to all ones right after its value is latched. With the reload enabled, each captured value is a direct measure of the time since the previous reloading event, so high time, low time or period can be read without any subtraction.

A second, independent 16-bit down-counter (counter 2) serves as a periodic system timer. Four pending flags record capture A, capture B, and the underflow of each counter. The flags stay set until they are cleared by writing a one. The combined interrupt line is raised by any pending flag whose enable bit is set. A registered read port returns either capture register or either counter. Either counter stops when the configuration asks it to count external events or to accumulate pulses, because input B is reserved for capture in this mode.

Top module: `dual_capture_timer`

## Requirements
- R1: After synchronous reset, both capture registers, the pending flags, the interrupt line and the read data are zero, and both counters hold 16'hFFFF.
- R2: A qualifying transition on pin A copies counter 1 into cap_a, and one on pin B copies it into cap_b. The new value is visible after the third rising clock edge that follows the pin change: two synchronizer stages, then the capture register.
- R3: rise_a/rise_b = 1 selects rising transitions and 0 selects falling transitions for that input. A transition of the opposite direction changes neither the capture register nor the pending flag.
- R4: When preset_a (preset_b) is set, a capture on that input latches the old counter value and loads counter 1 with 16'hFFFF on the same edge. A later capture that is D ticks after the reloading capture therefore reads 16'hFFFF - D + 1.
- R5: A level held for only one clock cycle on either pin is detected as a transition.
- R6: Pending bit 0 is set by a capture on A, bit 1 by a capture on B, bit 2 by an underflow of counter 1, and bit 3 by an underflow of counter 2.
- R7: Writing a one to a bit of pend_clr clears that pending bit. If a new event for the same bit arrives in the same cycle, the bit stays set.
- R8: irq is high exactly when some bit of pend has its matching bit of irq_en set.
- R9: Each counter decrements by one on each cycle in which its tick is high. A counter at 16'h0000 wraps to 16'hFFFF and sets its underflow pending bit. A counter whose tick is low holds its value.
- R10: While cnt1_ext_req (cnt2_ext_req) is high, that counter holds its value and raises no underflow.
- R11: With rd_en high, rd_data is loaded on the clock edge from rd_sel (0 cap_a, 1 cap_b, 2 counter 1, 3 counter 2). It gives the value held before that edge, even when a capture updates the same register on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick1 | input | 1 | Count enable for counter 1 |
| tick2 | input | 1 | Count enable for counter 2 |
| pin_a | input | 1 | Raw capture input A |
| pin_b | input | 1 | Raw capture input B |
| rise_a | input | 1 | Input A polarity: 1 rising, 0 falling |
| rise_b | input | 1 | Input B polarity: 1 rising, 0 falling |
| preset_a | input | 1 | Reload counter 1 after an A capture |
| preset_b | input | 1 | Reload counter 1 after a B capture |
| cnt1_ext_req | input | 1 | Counter 1 asked for an external-event or accumulate source (stops it) |
| cnt2_ext_req | input | 1 | Counter 2 asked for an external-event or accumulate source (stops it) |
| irq_en | input | 4 | Interrupt enables, one per pending bit |
| pend_clr | input | 4 | Write-one-to-clear strobes for the pending bits |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Read source select |
| rd_data | output | 16 | Registered read data |
| cap_a | output | 16 | Capture register A |
| cap_b | output | 16 | Capture register B |
| pend | output | 4 | Pending flags |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take three things for granted. The pins are low when reset ends, so the synchronizer's zero reset value creates no false transition. The ticks and configuration inputs change only between clock edges. A pin level lasts at least one full clock cycle. The bench drives every input one time unit after a rising edge and holds pins at each level for whole cycles. It keeps both pins low through every reset, so the stimulus stays within these limits.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int unsigned NUM_CAP = 2;
    localparam int unsigned NUM_SRC = 4;

    typedef enum logic [1:0] {
        SRC_CAP_A = 2'd0,
        SRC_CAP_B = 2'd1,
        SRC_UF1   = 2'd2,
        SRC_UF2   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        RD_CAP_A = 2'd0,
        RD_CAP_B = 2'd1,
        RD_CNT1  = 2'd2,
        RD_CNT2  = 2'd3
    } rdsel_e;

    typedef struct packed {
        logic rising;
        logic preset;
    } cap_cfg_t;

    function automatic logic edge_hit(input logic cur, input logic prev, input logic rising);
        return rising ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/dct_edge_detect.sv
module dct_edge_detect
    import dct_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rising,
    output logic hit
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], pin};
    end

    assign hit = edge_hit(chain[STAGES-1], chain[STAGES], rising);

endmodule

// File: rtl/dct_down_counter.sv
module dct_down_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         halt,
    input  logic         load,
    output logic [W-1:0] cnt,
    output logic         uflow
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic advance;
    assign advance = tick & ~halt & ~load;
    assign uflow   = advance & (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= ALL_ONES;
        else if (halt)    cnt <= cnt;
        else if (load)    cnt <= ALL_ONES;
        else if (advance) cnt <= cnt - 1'b1;
    end

    a_r10_halt_holds: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(cnt));

    a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !halt && !load && cnt == '0) |=> (cnt == ALL_ONES));

    a_r9_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !halt && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/dct_pending.sv
module dct_pending #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | set;
    end

    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((pend & $past(set)) == $past(set)));

    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~set) != '0) |=> ((pend & $past(clr & ~set)) == '0));

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> ((pend & $past(pend)) == $past(pend)));

endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
    import dct_pkg::*;
#(
    parameter int unsigned W           = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick1,
    input  logic                 tick2,
    input  logic                 pin_a,
    input  logic                 pin_b,
    input  logic                 rise_a,
    input  logic                 rise_b,
    input  logic                 preset_a,
    input  logic                 preset_b,
    input  logic                 cnt1_ext_req,
    input  logic                 cnt2_ext_req,
    input  logic [NUM_SRC-1:0]   irq_en,
    input  logic [NUM_SRC-1:0]   pend_clr,
    input  logic                 rd_en,
    input  logic [1:0]           rd_sel,
    output logic [W-1:0]         rd_data,
    output logic [W-1:0]         cap_a,
    output logic [W-1:0]         cap_b,
    output logic [NUM_SRC-1:0]   pend,
    output logic                 irq
);
    logic [NUM_CAP-1:0] pin_v;
    logic [NUM_CAP-1:0] hit;
    cap_cfg_t           cfg [NUM_CAP];
    logic [W-1:0]       cap_q [NUM_CAP];
    logic [W-1:0]       cnt1;
    logic [W-1:0]       cnt2;
    logic               uf1;
    logic               uf2;
    logic               load1;
    logic [NUM_CAP-1:0] preset_hit;
    logic [NUM_SRC-1:0] ev;

    assign pin_v  = {pin_b, pin_a};
    assign cfg[0] = '{rising: rise_a, preset: preset_a};
    assign cfg[1] = '{rising: rise_b, preset: preset_b};

    for (genvar g = 0; g < NUM_CAP; g++) begin : g_cap
        dct_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst    (rst),
            .pin    (pin_v[g]),
            .rising (cfg[g].rising),
            .hit    (hit[g])
        );

        assign preset_hit[g] = hit[g] & cfg[g].preset;

        always_ff @(posedge clk) begin
            if (rst)         cap_q[g] <= '0;
            else if (hit[g]) cap_q[g] <= cnt1;
        end
    end

    assign load1 = |preset_hit;

    dct_down_counter #(.W(W)) u_cnt1 (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick1),
        .halt  (cnt1_ext_req),
        .load  (load1),
        .cnt   (cnt1),
        .uflow (uf1)
    );

    dct_down_counter #(.W(W)) u_cnt2 (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick2),
        .halt  (cnt2_ext_req),
        .load  (1'b0),
        .cnt   (cnt2),
        .uflow (uf2)
    );

    always_comb begin
        ev            = '0;
        ev[SRC_CAP_A] = hit[0];
        ev[SRC_CAP_B] = hit[1];
        ev[SRC_UF1]   = uf1;
        ev[SRC_UF2]   = uf2;
    end

    dct_pending #(.N(NUM_SRC)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .set  (ev),
        .clr  (pend_clr),
        .pend (pend)
    );

    assign irq   = |(pend & irq_en);
    assign cap_a = cap_q[0];
    assign cap_b = cap_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (rdsel_e'(rd_sel))
                RD_CAP_A: rd_data <= cap_q[0];
                RD_CAP_B: rd_data <= cap_q[1];
                RD_CNT1:  rd_data <= cnt1;
                default:  rd_data <= cnt2;
            endcase
        end
    end

    a_r2_cap_a_copy: assert property (@(posedge clk) disable iff (rst)
        hit[0] |=> (cap_a == $past(cnt1)));

    a_r2_cap_b_copy: assert property (@(posedge clk) disable iff (rst)
        hit[1] |=> (cap_b == $past(cnt1)));

    a_r4_preset_loads: assert property (@(posedge clk) disable iff (rst)
        (load1 && !cnt1_ext_req) |=> (cnt1 == {W{1'b1}}));

    a_r11_read_old: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd0) |=> (rd_data == $past(cap_a)));

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);

endmodule

// File: tb/dual_capture_timer_bench.sv
module dual_capture_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick1 = 1'b1, tick2 = 1'b1;
    logic        pin_a = 1'b0, pin_b = 1'b0;
    logic        rise_a = 1'b1, rise_b = 1'b1;
    logic        preset_a = 1'b0, preset_b = 1'b0;
    logic        cnt1_ext_req = 1'b0, cnt2_ext_req = 1'b0;
    logic [3:0]  irq_en = 4'h0, pend_clr = 4'h0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data, cap_a, cap_b;
    logic [3:0]  pend;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_capture_timer u_dual_capture_timer (
        .clk(clk), .rst(rst), .tick1(tick1), .tick2(tick2),
        .pin_a(pin_a), .pin_b(pin_b), .rise_a(rise_a), .rise_b(rise_b),
        .preset_a(preset_a), .preset_b(preset_b),
        .cnt1_ext_req(cnt1_ext_req), .cnt2_ext_req(cnt2_ext_req),
        .irq_en(irq_en), .pend_clr(pend_clr), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .cap_a(cap_a), .cap_b(cap_b), .pend(pend), .irq(irq)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        rd_en = 1'b1;
        rd_sel = s;
        step();
        v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        pin_a = 1'b0;
        pin_b = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v1, v2, ca, cb, old;
        do_reset();
        // R1 reset state
        chk(cap_a == 16'h0, "R1 cap_a", cap_a, 0);
        chk(cap_b == 16'h0, "R1 cap_b", cap_b, 0);
        chk(pend == 4'h0, "R1 pend", pend, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
        rd(2'd2, v1);
        chk(v1 == 16'hFFFF, "R1 R11 counter1 reset value", v1, 16'hFFFF);

        // R4 R5 R3: high time, A rising presets, B falling captures
        rise_a = 1'b1; rise_b = 1'b0; preset_a = 1'b1; preset_b = 1'b0;
        for (int w = 1; w <= 6; w++) begin
            pin_a = 1'b1; pin_b = 1'b1;
            step(w);
            pin_a = 1'b0; pin_b = 1'b0;
            step(6);
            chk(cap_b == 16'hFFFF - 16'(w) + 16'd1, "R4 R5 high time", cap_b, 16'hFFFF - 16'(w) + 16'd1);
        end

        // R4 R5: period on A alone with one-cycle high pulses
        rise_a = 1'b1; preset_a = 1'b1; preset_b = 1'b0;
        for (int p = 3; p <= 8; p++) begin
            pin_a = 1'b1; step(1); pin_a = 1'b0; step(p - 1);
            pin_a = 1'b1; step(1); pin_a = 1'b0; step(6);
            chk(cap_a == 16'hFFFF - 16'(p) + 16'd1, "R4 R5 period", cap_a, 16'hFFFF - 16'(p) + 16'd1);
        end

        // R3 R4: low time, B falling presets, A rising captures
        rise_a = 1'b1; rise_b = 1'b0; preset_a = 1'b0; preset_b = 1'b1;
        for (int l = 1; l <= 5; l++) begin
            pin_a = 1'b1; pin_b = 1'b1; step(6);
            pin_a = 1'b0; pin_b = 1'b0; step(l);
            pin_a = 1'b1; pin_b = 1'b1; step(6);
            chk(cap_a == 16'hFFFF - 16'(l) + 16'd1, "R3 R4 low time", cap_a, 16'hFFFF - 16'(l) + 16'd1);
            pin_a = 1'b0; pin_b = 1'b0; step(6);
        end

        // R2: no preset, gap between A and B captures
        rise_a = 1'b1; rise_b = 1'b1; preset_a = 1'b0; preset_b = 1'b0;
        for (int g = 1; g <= 4; g++) begin
            pin_a = 1'b1; step(g);
            pin_b = 1'b1; step(6);
            chk(16'(cap_a - cap_b) == 16'(g), "R2 capture gap", 16'(cap_a - cap_b), g);
            if (g < 4) begin
                pin_a = 1'b0; pin_b = 1'b0; step(6);
            end
        end

        // R3: falling transitions ignored under rising polarity
        pend_clr = 4'hF; step(); pend_clr = 4'h0;
        ca = cap_a; cb = cap_b;
        pin_a = 1'b0; pin_b = 1'b0; step(6);
        chk(pend[1:0] == 2'b00, "R3 ignored edge pend", pend[1:0], 0);
        chk(cap_a == ca && cap_b == cb, "R3 ignored edge caps", cap_a, ca);

        // R6 R8: capture on A sets bit 0, irq follows enables
        pin_a = 1'b1; step(4);
        chk(pend == 4'b0001, "R6 pend after A", pend, 4'b0001);
        chk(irq == 1'b0, "R8 irq masked", irq, 0);
        irq_en = 4'b0001; #1;
        chk(irq == 1'b1, "R8 irq enabled", irq, 1);
        irq_en = 4'b1110; #1;
        chk(irq == 1'b0, "R8 irq other enables", irq, 0);
        pin_b = 1'b1; step(4);
        chk(pend == 4'b0011 && irq == 1'b1, "R6 R8 pend after B", {pend, 3'b0, irq}, {4'b0011, 4'b0001});
        irq_en = 4'h0;

        // R7 R11: clear and read colliding with a capture
        pin_a = 1'b0; step(6);
        old = cap_a;
        pin_a = 1'b1; step(2);
        pend_clr = 4'b0001; rd_en = 1'b1; rd_sel = 2'd0;
        step();
        pend_clr = 4'b0000; rd_en = 1'b0;
        chk(pend[0] == 1'b1, "R7 event wins over clear", pend[0], 1);
        chk(rd_data == old, "R11 read returns old capture", rd_data, old);
        chk(cap_a != old, "R2 capture updated", cap_a, old);
        pend_clr = 4'b0011; step(); pend_clr = 4'b0000;
        chk(pend[1:0] == 2'b00, "R7 clear", pend[1:0], 0);

        // R10: requested external source stops the counter
        cnt2_ext_req = 1'b1;
        rd(2'd3, v1); step(20); rd(2'd3, v2);
        chk(v1 == v2, "R10 counter2 halted", v2, v1);
        cnt1_ext_req = 1'b1;
        rd(2'd2, v1); step(20); rd(2'd2, v2);
        chk(v1 == v2, "R10 counter1 halted", v2, v1);
        cnt1_ext_req = 1'b0; cnt2_ext_req = 1'b0;

        // R9: tick gating and stepping
        tick1 = 1'b0;
        rd(2'd2, v1); step(7); rd(2'd2, v2);
        chk(v1 == v2, "R9 no tick holds", v2, v1);
        tick1 = 1'b1;
        rd(2'd2, v1); step(9); rd(2'd2, v2);
        chk(16'(v1 - v2) == 16'd10, "R9 decrement per tick", 16'(v1 - v2), 10);

        // R9 R6: underflow of both counters from reset
        do_reset();
        tick1 = 1'b1; tick2 = 1'b1;
        step(9);
        rd(2'd2, v1);
        chk(v1 == 16'hFFF6, "R9 R11 counter1 after ten ticks", v1, 16'hFFF6);
        step(65525);
        chk(pend == 4'b0000, "R9 no underflow yet", pend, 0);
        step();
        chk(pend == 4'b1100, "R9 R6 underflow flags", pend, 4'b1100);
        rd(2'd2, v1);
        chk(v1 == 16'hFFFF, "R9 wrap to all ones", v1, 16'hFFFF);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule